// File: doc/BRIEF.md
# Serial Programming Port for an Integer-N Synthesizer

This block receives programming words for an integer-N frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. All three pins are brought into the system clock domain through synchronizer chains. A rising serial clock shifts one data bit into a 22-bit register, most significant bit first. A rising load strobe hands the whole register to a decoder. The decoder reads the two lowest bits of the word to pick the destination and then updates either the reference-divider latch or the dual-modulus counter latch.

The latched fields go straight to the divider and loop-control logic as registered outputs. These are the reference count, the A and B counts, the prescaler modulus select, RF power-down, charge-pump gain, phase-detector polarity, the charge-pump high-impedance control and the test-output multiplexer select. A word that would program a forbidden divide value is discarded, so the previous setting stays in force, and a sticky error flag is raised. The RF section stays powered down from reset until a valid counter word has been accepted.

Top module: `synth_prog_port`

## Requirements
- R1: Each rising serial clock shifts the data bit in at the low end of a 22-bit register, so the first bit sent ends up as DB21. When more than 22 bits are sent before a load, only the last 22 count.
- R2: A load whose word has DB1=1 and DB0=0 addresses the reference latch, and the 14-bit reference count is taken from DB15:DB2, with DB2 as its LSB.
- R3: A reference word also sets the charge-pump gain from DB16, the phase-detector polarity from DB17, the charge-pump high-impedance control from DB18 and the 3-bit mux select from DB21:DB19, with DB19 as the LSB.
- R4: A load whose word has DB1=1 and DB0=1 addresses the counter latch. It takes the 6-bit A count from DB7:DB2, the 11-bit B count from DB18:DB8, the prescaler select from DB19 and the RF power-down request from DB21.
- R5: A reference word whose count is zero changes no output except the error flag, which goes to 1.
- R6: A counter word whose B count is below 3, or whose reserved bit DB20 is 1, changes no output except the error flag, which goes to 1.
- R7: A load whose word has DB1=0 (control codes 00 and 01) changes no output.
- R8: During and after reset, every count and control output is 0, RF power-down is 1 and the error flag is 0.
- R9: RF power-down stays 1 until the first accepted counter word arrives. From then on it equals DB21 of the most recently accepted counter word.
- R10: Once set, the error flag stays 1 until reset, and legal words sent after an error are still applied.
- R11: The latches update only on a rising load strobe. Serial clocks alone never change an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| sdata_i | input | 1 | Serial data pin (asynchronous) |
| le_i | input | 1 | Load strobe pin (asynchronous) |
| r_count_o | output | 14 | Reference divider count |
| a_count_o | output | 6 | A (swallow) count |
| b_count_o | output | 11 | B count |
| presc_sel_o | output | 1 | Prescaler modulus select (0: 64/65, 1: 32/33) |
| rf_pd_o | output | 1 | RF section power-down |
| cp_gain_o | output | 1 | Charge-pump gain select (0 low, 1 high) |
| pd_pol_o | output | 1 | Phase-detector polarity (0 negative, 1 positive) |
| cp_tri_o | output | 1 | Charge-pump high-impedance control |
| mux_sel_o | output | 3 | Test output multiplexer select |
| prog_err_o | output | 1 | Sticky forbidden-value flag |

## Verification
The bench builds the block with the default frame layout (22-bit word, 14-bit R, 6-bit A, 11-bit B) and a two-stage synchronizer. It sweeps all four control codes and every B value from 0 to 8, which covers both sides of the forbidden-B boundary. It also sweeps R from 0 to 4 plus the full-scale 16383, and all eight mux codes together with the flag bits. The default widths let the same stimulus reach the top codes of every field, and an overlong burst of serial bits checks that earlier bits fall off the top of the register.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  typedef enum logic [1:0] {
    CTL_NONE  = 2'b00,
    CTL_SPARE = 2'b01,
    CTL_REF   = 2'b10,
    CTL_AB    = 2'b11
  } ctl_e;

  localparam int MUX_W = 3;
  localparam int CTL_W = 2;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_shift.sv
module sp_shift #(
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              sdi,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], sdi};
  end
endmodule

// File: rtl/sp_latch_dec.sv
module sp_latch_dec
  import synth_prog_pkg::*;
#(
  parameter int WORD_W = 22,
  parameter int R_W    = 14,
  parameter int A_W    = 6,
  parameter int B_W    = 11,
  parameter int B_MIN  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [R_W-1:0]    r_count,
  output logic [A_W-1:0]    a_count,
  output logic [B_W-1:0]    b_count,
  output logic              presc_sel,
  output logic              rf_pd,
  output logic              cp_gain,
  output logic              pd_pol,
  output logic              cp_tri,
  output logic [MUX_W-1:0]  mux_sel,
  output logic              prog_err
);
  localparam int R_LSB     = CTL_W;
  localparam int GAIN_POS  = R_LSB + R_W;
  localparam int POL_POS   = GAIN_POS + 1;
  localparam int TRI_POS   = POL_POS + 1;
  localparam int MUX_LSB   = TRI_POS + 1;
  localparam int A_LSB     = CTL_W;
  localparam int B_LSB     = A_LSB + A_W;
  localparam int PRE_POS   = B_LSB + B_W;
  localparam int RSV_POS   = PRE_POS + 1;
  localparam int PD_POS    = WORD_W - 1;

  ctl_e            ctl;
  logic [R_W-1:0]  r_fld;
  logic [A_W-1:0]  a_fld;
  logic [B_W-1:0]  b_fld;
  logic            r_bad;
  logic            ab_bad;

  always_comb begin
    ctl    = ctl_e'(word[CTL_W-1:0]);
    r_fld  = word[R_LSB +: R_W];
    a_fld  = word[A_LSB +: A_W];
    b_fld  = word[B_LSB +: B_W];
    r_bad  = (r_fld == '0);
    ab_bad = (b_fld < B_W'(B_MIN)) || word[RSV_POS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_count   <= '0;
      a_count   <= '0;
      b_count   <= '0;
      presc_sel <= 1'b0;
      rf_pd     <= 1'b1;
      cp_gain   <= 1'b0;
      pd_pol    <= 1'b0;
      cp_tri    <= 1'b0;
      mux_sel   <= '0;
      prog_err  <= 1'b0;
    end else if (load) begin
      case (ctl)
        CTL_REF: begin
          if (r_bad) begin
            prog_err <= 1'b1;
          end else begin
            r_count <= r_fld;
            cp_gain <= word[GAIN_POS];
            pd_pol  <= word[POL_POS];
            cp_tri  <= word[TRI_POS];
            mux_sel <= word[MUX_LSB +: MUX_W];
          end
        end
        CTL_AB: begin
          if (ab_bad) begin
            prog_err <= 1'b1;
          end else begin
            a_count   <= a_fld;
            b_count   <= b_fld;
            presc_sel <= word[PRE_POS];
            rf_pd     <= word[PD_POS];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
  import synth_prog_pkg::*;
#(
  parameter int WORD_W      = 22,
  parameter int R_W         = 14,
  parameter int A_W         = 6,
  parameter int B_W         = 11,
  parameter int B_MIN       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             le_i,
  output logic [R_W-1:0]   r_count_o,
  output logic [A_W-1:0]   a_count_o,
  output logic [B_W-1:0]   b_count_o,
  output logic             presc_sel_o,
  output logic             rf_pd_o,
  output logic             cp_gain_o,
  output logic             pd_pol_o,
  output logic             cp_tri_o,
  output logic [MUX_W-1:0] mux_sel_o,
  output logic             prog_err_o
);
  logic              sclk_s, sdata_s, le_s;
  logic              sclk_d, le_d;
  logic              shift_stb, load_stb;
  logic [WORD_W-1:0] word;

  sp_sync #(.STAGES(SYNC_STAGES)) i_sync_sclk (.clk(clk), .rst(rst), .din(sclk_i),  .q(sclk_s));
  sp_sync #(.STAGES(SYNC_STAGES)) i_sync_data (.clk(clk), .rst(rst), .din(sdata_i), .q(sdata_s));
  sp_sync #(.STAGES(SYNC_STAGES)) i_sync_le   (.clk(clk), .rst(rst), .din(le_i),    .q(le_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      le_d      <= 1'b0;
      shift_stb <= 1'b0;
      load_stb  <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      le_d      <= le_s;
      shift_stb <= sclk_s & ~sclk_d;
      load_stb  <= le_s & ~le_d;
    end
  end

  sp_shift #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst(rst), .shift_en(shift_stb), .sdi(sdata_s), .word(word)
  );

  sp_latch_dec #(
    .WORD_W(WORD_W), .R_W(R_W), .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)
  ) i_dec (
    .clk(clk), .rst(rst), .load(load_stb), .word(word),
    .r_count(r_count_o), .a_count(a_count_o), .b_count(b_count_o),
    .presc_sel(presc_sel_o), .rf_pd(rf_pd_o), .cp_gain(cp_gain_o),
    .pd_pol(pd_pol_o), .cp_tri(cp_tri_o), .mux_sel(mux_sel_o),
    .prog_err(prog_err_o)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int R_W   = 14,
  parameter int B_W   = 11,
  parameter int B_MIN = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           load_stb,
  input logic [R_W-1:0] r_count,
  input logic [B_W-1:0] b_count,
  input logic           rf_pd,
  input logic           prog_err
);
  // R10: error flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    prog_err |=> prog_err);

  // R5: reference count only ever moves to a legal value
  p_r_legal_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(r_count) |-> (r_count != '0));

  // R6: B count only ever moves to a legal value
  p_b_legal_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(b_count) |-> (b_count >= B_W'(B_MIN)));

  // R11: latch contents move only right after a load strobe
  p_load_only_r11: assert property (@(posedge clk) disable iff (rst)
    (!$stable(r_count) || !$stable(b_count)) |-> $past(load_stb));

  // R9: RF stays powered down while no counter word has been accepted
  p_pd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (b_count < B_W'(B_MIN)) |-> rf_pd);
endmodule

bind synth_prog_port sp_checker #(.R_W(R_W), .B_W(B_W), .B_MIN(B_MIN)) i_sp_checker (
  .clk(clk), .rst(rst), .load_stb(load_stb), .r_count(r_count_o),
  .b_count(b_count_o), .rf_pd(rf_pd_o), .prog_err(prog_err_o)
);

// File: tb/test_synth_prog_port.sv
module test_synth_prog_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_i = 1'b0, sdata_i = 1'b0, le_i = 1'b0;
  logic [13:0] r_count_o;
  logic [5:0]  a_count_o;
  logic [10:0] b_count_o;
  logic presc_sel_o, rf_pd_o, cp_gain_o, pd_pol_o, cp_tri_o, prog_err_o;
  logic [2:0]  mux_sel_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  logic [13:0] e_r;  logic [5:0] e_a;  logic [10:0] e_b;
  logic e_pre, e_pd, e_gain, e_pol, e_tri, e_err;  logic [2:0] e_mux;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_prog_port i_synth_prog_port (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdata_i(sdata_i), .le_i(le_i),
    .r_count_o(r_count_o), .a_count_o(a_count_o), .b_count_o(b_count_o),
    .presc_sel_o(presc_sel_o), .rf_pd_o(rf_pd_o), .cp_gain_o(cp_gain_o),
    .pd_pol_o(pd_pol_o), .cp_tri_o(cp_tri_o), .mux_sel_o(mux_sel_o),
    .prog_err_o(prog_err_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "r_count", r_count_o, e_r);
    cmp(tag, "a_count", a_count_o, e_a);
    cmp(tag, "b_count", b_count_o, e_b);
    cmp(tag, "presc", presc_sel_o, e_pre);
    cmp(tag, "rf_pd", rf_pd_o, e_pd);
    cmp(tag, "cp_gain", cp_gain_o, e_gain);
    cmp(tag, "pd_pol", pd_pol_o, e_pol);
    cmp(tag, "cp_tri", cp_tri_o, e_tri);
    cmp(tag, "mux_sel", mux_sel_o, e_mux);
    cmp(tag, "prog_err", prog_err_o, e_err);
  endtask

  task automatic model_reset();
    e_r = 0; e_a = 0; e_b = 0; e_pre = 0; e_pd = 1;
    e_gain = 0; e_pol = 0; e_tri = 0; e_mux = 0; e_err = 0;
  endtask

  // Expected effect of a load, computed from the field positions in R2..R7
  task automatic model_load(input logic [21:0] w);
    if (w[1:0] == 2'b10) begin
      if (w[15:2] == 0) e_err = 1;
      else begin
        e_r = w[15:2]; e_gain = w[16]; e_pol = w[17]; e_tri = w[18]; e_mux = w[21:19];
      end
    end else if (w[1:0] == 2'b11) begin
      if (w[18:8] < 3 || w[20]) e_err = 1;
      else begin
        e_a = w[7:2]; e_b = w[18:8]; e_pre = w[19]; e_pd = w[21];
      end
    end
  endtask

  task automatic send_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_i = bits[i];
      sclk_i = 1'b0;
      repeat (3) @(negedge clk);
      sclk_i = 1'b1;
      repeat (3) @(negedge clk);
    end
    sclk_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    le_i = 1'b1;
    repeat (4) @(negedge clk);
    le_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_word(input logic [21:0] w, input string tag);
    send_bits({42'd0, w}, 22);
    strobe();
    model_load(w);
    check_all(tag);
  endtask

  function automatic logic [21:0] mk_ref(input int r, input bit g, input bit p,
                                         input bit t, input int m);
    return {m[2:0], t, p, g, r[13:0], 2'b10};
  endfunction

  function automatic logic [21:0] mk_ab(input bit pd, input bit rsv, input bit pre,
                                        input int b, input int a);
    return {pd, rsv, pre, b[10:0], a[5:0], 2'b11};
  endfunction

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    check_all("R8 in reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R8 after reset");

    // R11: serial clocks without a load leave outputs alone
    send_bits({42'd0, mk_ab(0, 0, 1, 100, 7)}, 22);
    check_all("R11 no load");

    // R7: control codes 00 and 01 ignored
    send_word(22'h3FFFFC, "R7 code00");
    send_word(22'h3FFFFD, "R7 code01");

    // R9: still powered down before any counter word
    send_word(mk_ref(5, 1, 0, 1, 2), "R9 ref keeps pd");

    // R2/R5: sweep small R values and full scale
    for (int r = 0; r < 5; r++) send_word(mk_ref(r, r[0], r[1], r[2], r), r == 0 ? "R5 r zero" : "R2 r sweep");
    send_word(mk_ref(16383, 0, 1, 0, 6), "R2 r max");

    // R3: every mux code with flag patterns
    for (int m = 0; m < 8; m++) send_word(mk_ref(100 + m, m[1], m[0], m[2], m), "R3 flags");

    // R4/R6/R9: B sweep across the forbidden boundary
    for (int b = 0; b < 9; b++)
      send_word(mk_ab(b[0], 0, b[1], b, 60 + b % 4), b < 3 ? "R6 b low" : "R4 b sweep");
    send_word(mk_ab(0, 0, 1, 2047, 63), "R4 b max");
    send_word(mk_ab(1, 1, 0, 500, 9), "R6 reserved bit");
    send_word(mk_ab(0, 0, 0, 3, 0), "R9 pd follows");
    send_word(mk_ab(1, 0, 0, 4, 1), "R9 pd set");

    // R10: error held, legal words still applied
    cmp("R10", "err sticky", prog_err_o, 1);
    send_word(mk_ref(77, 1, 1, 0, 5), "R10 applied after error");

    // R1: overlong burst, only last 22 bits count
    send_bits({22'h155555, 20'hABCDE, mk_ab(0, 0, 1, 1234, 33)}, 64);
    strobe();
    model_load(mk_ab(0, 0, 1, 1234, 33));
    check_all("R1 overlong burst");
    send_bits({22'h0, 20'h0, mk_ref(4321, 0, 0, 1, 3)}, 64);
    strobe();
    model_load(mk_ref(4321, 0, 0, 1, 3));
    check_all("R1 msb first");

    // R8: reset clears error and latches
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check_all("R8 re-reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule